// File: doc/BRIEF.md
# Program Bank Outer Address Translator

This block turns the cartridge's outer banking registers and the inner bank values into the upper program-ROM address bits for the CPU window being accessed. The program space from 0x8000 to 0xFFFF is split into four 8 KB windows. The window index is CPU address bits A14:A13, so 0 selects 0x8000 and 3 selects 0xE000. The block also selects which RAM page appears in the 0x6000–0x7FFF window.

A three-bit mode field in outer register 0 chooses the banking scheme:

- Three 8 KB schemes, in which the inner bank value supplies 6, 5 or 4 low bits.
- A 16 KB scheme, in which one 16 KB bank is mirrored at 0x8000 and 0xC000.
- A 32 KB scheme, in which one bank covers the whole program space.

In the 8 KB schemes, an override can hand the two upper windows to outer registers 4 and 5. Three outer "high block" bits extend the reach of the outer registers. Boards that carry CHR RAM gain one more such bit.

Both results are registered, so they appear one clock after the inputs that produce them. The surrounding logic holds the inputs steady for the access.

Top module: `prg_outer_xlat`

## Requirements
- R1: While `rst_n` is low, `prg_bank` and `ram_page` are 0.
- R2: Both outputs reflect the inputs sampled at the previous rising clock edge. `win` (CPU A14:A13) selects the window: 0 selects 0x8000, 1 selects 0xA000, 2 selects 0xC000 and 3 selects 0xE000.
- R3: The high-block value hb is a 10-bit field with three live bits:
  - hb bit 7 = `outer0[3]`.
  - hb bit 8 = `outer0[7]`.
  - hb bit 9 = `blk_ext` AND `chr_ram`. So `blk_ext` has no effect when `chr_ram` is 0.
  - All other bits of hb are 0.
- R4: When mode `outer0[2:0]` is 0, or any of 5, 6 or 7, bank = ((hb | (`outer1` & 0x60)) << 1) | (inner & 0x3F). Here inner is the 8-bit inner value for the selected window.
- R5: In mode 1, bank = ((hb | (`outer1` & 0x70)) << 1) | (inner & 0x1F).
- R6: In mode 2, bank = ((hb | (`outer1` & 0x78)) << 1) | (inner & 0x0F).
- R7: In mode 3, let V = (`outer1` & 0x7F) | hb. Then bank = (V << 1) | `win[0]`, so window 0 and window 2 return the same value.
- R8: In mode 4, bank = ((V >> 1) << 2) | `win`.
- R9: In modes 0–2 and 5–7, when `outer3[1]` is 1, window 2 returns `outer4` and window 3 returns `outer5`, each zero-extended. The override has no effect on windows 0 and 1, and none in modes 3 and 4.
- R10: `ram_page` equals `ram_ctl[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win | input | 2 | CPU address bits A14:A13 |
| outer0 | input | 8 | Outer register 0: mode and high-block bits |
| outer1 | input | 8 | Outer register 1: outer bank bits |
| blk_ext | input | 1 | Extra high-block bit (register 2 bit 6) |
| outer3 | input | 8 | Outer register 3: bit 1 enables the upper-window override |
| outer4 | input | 8 | Override bank for window 2 |
| outer5 | input | 8 | Override bank for window 3 |
| inner_bank | input | 32 | Four 8-bit inner bank values, window n at bits [8n+7:8n] |
| ram_ctl | input | 8 | Inner RAM-control value |
| chr_ram | input | 1 | Board carries CHR RAM |
| prg_bank | output | 11 | 8 KB program-ROM bank for the selected window |
| ram_page | output | 2 | RAM page for 0x6000–0x7FFF |

## Verification
In one cycle, the mode's outer/inner bit split can meet the upper-window override, and the high-block bits can meet both. The sweep runs every mode against every window with the override bit both set and clear, with `chr_ram` and `blk_ext` in all combinations, and over several register patterns. Each result is judged against a value computed arithmetically from the formulas, one cycle after the inputs are applied. The RAM page is compared on the same cycle as the bank, so an update to one that disturbs the other is caught.

// File: rtl/prg_xlat_pkg.sv
package prg_xlat_pkg;
    parameter int REG_W   = 8;
    parameter int INNER_W = 8;
    parameter int HB_W    = 10;
    parameter int BANK_W  = HB_W + 1;
    parameter int WINS    = 4;
    parameter int PAGE_W  = 2;

    typedef enum logic [2:0] {
        MODE_8K_W6 = 3'd0,
        MODE_8K_W5 = 3'd1,
        MODE_8K_W4 = 3'd2,
        MODE_16K   = 3'd3,
        MODE_32K   = 3'd4
    } bank_mode_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [PAGE_W-1:0] page;
    } xlat_state_t;
endpackage

// File: rtl/prg_hiblk.sv
module prg_hiblk
    import prg_xlat_pkg::*;
(
    input  logic            r0_b3,
    input  logic            r0_b7,
    input  logic            blk_ext,
    input  logic            chr_ram,
    output logic [HB_W-1:0] hb
);
    always_comb begin
        hb    = '0;
        hb[7] = r0_b3;
        hb[8] = r0_b7;
        hb[9] = blk_ext & chr_ram;
    end
endmodule

// File: rtl/prg_win_map.sv
module prg_win_map
    import prg_xlat_pkg::*;
#(
    parameter int WIN = 0
) (
    input  logic [2:0]         mode,
    input  logic [REG_W-1:0]   r1,
    input  logic [HB_W-1:0]    hb,
    input  logic [INNER_W-1:0] inner,
    input  logic               ovr_en,
    input  logic [REG_W-1:0]   ovr_val,
    output logic [BANK_W-1:0]  bank
);
    localparam bit         HAS_OVR = (WIN >= 2);
    localparam logic [1:0] WIN_IDX = 2'(WIN);

    logic [HB_W-1:0] r1_x;
    logic [HB_W-1:0] v16;

    assign r1_x = HB_W'(r1);
    assign v16  = (r1_x & HB_W'('h7F)) | hb;

    always_comb begin
        unique case (mode)
            MODE_8K_W5: bank = {hb | (r1_x & HB_W'('h70)), 1'b0}
                             | BANK_W'(inner & INNER_W'('h1F));
            MODE_8K_W4: bank = {hb | (r1_x & HB_W'('h78)), 1'b0}
                             | BANK_W'(inner & INNER_W'('h0F));
            MODE_16K:   bank = {v16, WIN_IDX[0]};
            MODE_32K:   bank = {v16[HB_W-1:1], WIN_IDX};
            default:    bank = {hb | (r1_x & HB_W'('h60)), 1'b0}
                             | BANK_W'(inner & INNER_W'('h3F));
        endcase
        if (HAS_OVR && ovr_en && mode != MODE_16K && mode != MODE_32K)
            bank = BANK_W'(ovr_val);
    end
endmodule

// File: rtl/prg_outer_xlat.sv
module prg_outer_xlat
    import prg_xlat_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              win,
    input  logic [REG_W-1:0]        outer0,
    input  logic [REG_W-1:0]        outer1,
    input  logic                    blk_ext,
    input  logic [REG_W-1:0]        outer3,
    input  logic [REG_W-1:0]        outer4,
    input  logic [REG_W-1:0]        outer5,
    input  logic [WINS*INNER_W-1:0] inner_bank,
    input  logic [REG_W-1:0]        ram_ctl,
    input  logic                    chr_ram,
    output logic [BANK_W-1:0]       prg_bank,
    output logic [PAGE_W-1:0]       ram_page
);
    logic [HB_W-1:0]   hb;
    logic [BANK_W-1:0] win_bank [WINS];
    xlat_state_t       st_d, st_q;
    logic              unused_bits;

    assign unused_bits = ^{outer0[6:4], outer3[7:2], outer3[0], ram_ctl[7:2]};

    prg_hiblk u_hiblk (
        .r0_b3  (outer0[3]),
        .r0_b7  (outer0[7]),
        .blk_ext(blk_ext),
        .chr_ram(chr_ram),
        .hb     (hb)
    );

    for (genvar w = 0; w < WINS; w++) begin : g_win
        prg_win_map #(.WIN(w)) u_map (
            .mode   (outer0[2:0]),
            .r1     (outer1),
            .hb     (hb),
            .inner  (inner_bank[w*INNER_W +: INNER_W]),
            .ovr_en (outer3[1]),
            .ovr_val((w == 3) ? outer5 : outer4),
            .bank   (win_bank[w])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.bank = win_bank[win];
        st_d.page = ram_ctl[PAGE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prg_bank = st_q.bank;
    assign ram_page = st_q.page;

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (prg_bank == '0 && ram_page == '0));

    assert_ram_page_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ram_page == $past(ram_ctl[1:0]));

    assert_mode32_low_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(outer0[2:0]) == 3'd4) |-> prg_bank[1:0] == $past(win));

    assert_mode16_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(outer0[2:0]) == 3'd3) |-> prg_bank[0] == $past(win[0]));

    assert_upper_override_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(outer0[2:0]) < 3'd3 && $past(outer3[1]) && $past(win) == 2'd3)
        |-> prg_bank == BANK_W'($past(outer5)));

    assert_hb_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(chr_ram) && $past(outer0[2:0]) == 3'd3) |-> !prg_bank[10]);
endmodule

// File: tb/prg_outer_xlat_tb.sv
`timescale 1ns/1ps
module prg_outer_xlat_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  win = '0;
    logic [7:0]  outer0 = '0, outer1 = '0, outer3 = '0, outer4 = '0, outer5 = '0;
    logic        blk_ext = 1'b0, chr_ram = 1'b0;
    logic [31:0] inner_bank = '0;
    logic [7:0]  ram_ctl = '0;
    logic [10:0] prg_bank;
    logic [1:0]  ram_page;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #2.5 clk = ~clk;

    prg_outer_xlat u_dut (
        .clk(clk), .rst_n(rst_n), .win(win), .outer0(outer0), .outer1(outer1),
        .blk_ext(blk_ext), .outer3(outer3), .outer4(outer4), .outer5(outer5),
        .inner_bank(inner_bank), .ram_ctl(ram_ctl), .chr_ram(chr_ram),
        .prg_bank(prg_bank), .ram_page(ram_page)
    );

    function automatic int exp_bank(input int m, input int w);
        int hb, r1, inn, v;
        hb  = (int'(outer0[3]) << 7) | (int'(outer0[7]) << 8) | (int'(blk_ext & chr_ram) << 9);
        r1  = int'(outer1);
        inn = int'(inner_bank[w*8 +: 8]);
        v   = (r1 & 'h7F) | hb;
        if (m != 3 && m != 4 && outer3[1] && w == 2) return int'(outer4);
        if (m != 3 && m != 4 && outer3[1] && w == 3) return int'(outer5);
        case (m)
            1: return (((hb | (r1 & 'h70)) << 1) | (inn & 'h1F)) & 'h7FF;
            2: return (((hb | (r1 & 'h78)) << 1) | (inn & 'h0F)) & 'h7FF;
            3: return ((v << 1) | (w & 1)) & 'h7FF;
            4: return (((v >> 1) << 2) | w) & 'h7FF;
            default: return (((hb | (r1 & 'h60)) << 1) | (inn & 'h3F)) & 'h7FF;
        endcase
    endfunction

    function automatic string tag_of(input int m, input int w);
        if (m != 3 && m != 4 && outer3[1] && w >= 2) return "R9";
        case (m)
            1: return "R5";
            2: return "R6";
            3: return "R7";
            4: return "R8";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    initial begin
        #200000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int exp;
        outer0     = 8'hFF;
        ram_ctl    = 8'h03;
        inner_bank = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R1", int'(prg_bank), 0);
        check("R1", int'(ram_page), 0);
        rst_n = 1'b1;
        for (int seed = 0; seed < 8; seed++) begin
            for (int m = 0; m < 8; m++) begin
                for (int combo = 0; combo < 8; combo++) begin
                    for (int w = 0; w < 4; w++) begin
                        @(negedge clk);
                        lfsr = step(lfsr); outer1 = lfsr[7:0]; outer4 = lfsr[15:8];
                        outer5 = lfsr[23:16]; ram_ctl = lfsr[31:24];
                        lfsr = step(step(lfsr)); inner_bank = lfsr;
                        lfsr = step(lfsr);
                        outer0  = {lfsr[3], 3'(lfsr[6:4]), lfsr[7], 3'(m)};
                        outer3  = {6'(lfsr[13:8]), combo[0], lfsr[14]};
                        chr_ram = combo[1];
                        blk_ext = combo[2];
                        win     = 2'(w);
                        exp     = exp_bank(m, w);
                        @(negedge clk);
                        check(tag_of(m, w), int'(prg_bank), exp);
                        check("R10", int'(ram_page), int'(ram_ctl[1:0]));
                    end
                end
            end
        end
        // R2: output follows a window change one cycle later, not the same cycle
        @(negedge clk);
        outer0 = 8'h03; outer1 = 8'h15; chr_ram = 1'b0;
        win = 2'd0;
        @(negedge clk);
        win = 2'd1;
        #1;
        check("R2", int'(prg_bank), 'h2A);
        @(negedge clk);
        check("R2", int'(prg_bank), 'h2B);
        // R3: blk_ext ignored without CHR RAM, honoured with it
        blk_ext = 1'b1; chr_ram = 1'b0; outer0 = 8'h04; outer1 = 8'h00; win = 2'd0;
        @(negedge clk);
        check("R3", int'(prg_bank), 0);
        chr_ram = 1'b1;
        @(negedge clk);
        check("R3", int'(prg_bank), 'h400);
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule